// File: doc/BRIEF.md
# Compare Timer with Period Restart

A 32-bit up-counting timer that sits on a plain word-indexed register bus (index, write strobe, write data, combinational read data) and drives one level-sensitive interrupt line. The count advances on tick enables from one of four sources chosen by a 3-bit select field. A 12-bit prescaler then divides those ticks. Three compare registers raise status flags when the count reaches them, and a wrap from all ones to zero raises a rollover flag.

In restart mode the first compare register sets the period: the count runs from zero up to that value, then starts again at zero. In free-run mode the count runs through its full range. Software can reset the block by writing a control bit, which keeps the run and source settings. The counter is reset on enable only when the enable-mode bit asks for it. The two capture registers are present only as zero read-back.

Top module: `cmp_timer`

## Requirements
- R1: Word indices are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2, 9 counter. Indices 7, 8 and 10 to 15 read zero. Writes to indices 7 to 15 have no effect.
- R2: The prescaler keeps data bits 11:0. The counter advances once for every prescaler+1 ticks of the selected source, counted while the timer is enabled.
- R3: Control bits 8:6 select the source: code 1 takes src_tick_i[0], code 2 takes [1], code 3 takes [2] and code 4 takes [3]. Codes 0, 5, 6 and 7 give no ticks, so the counter does not move.
- R4: Status bits 5:0 are cleared by writing 1 to them. A flag set in the same cycle as the clear stays set. The interrupt-enable register keeps only data bits 5:0.
- R5: irq_o is high exactly when control bit 0 (enable) is 1 and status AND interrupt-enable is nonzero.
- R6: In restart mode (control bit 9 clear), the counter reaching compare 1 sets status bit 0. The next step takes the counter to 0.
- R7: When the counter steps from all ones, it goes to 0 and sets status bit 5. In free-run mode (bit 9 set), every step adds 1.
- R8: When the counter takes the value of compare 2 or compare 3, status bit 1 or bit 2 is set. The count is not altered. Every flag is set whatever the interrupt-enable register holds.
- R9: In restart mode, writing compare 1 sets the counter and the prescaler phase to 0. In free-run mode the count is left as it is.
- R10: A control write that moves bit 0 from 0 to 1 with bit 1 (enable-mode) set starts the counter from 0. With bit 1 clear the counter resumes from its held value. While bit 0 is 0 the counter holds.
- R11: After rst_ni, control, prescaler, status, interrupt enable, counter and captures read 0, and the three compare registers read all ones.
- R12: Writing control with bit 15 set has the same effect as reset, except that bits 0, 1, 3, 5, 8:6, 16 and 17 take the written values. Bit 15 then reads 0.
- R13: Control bits set in mask 0x7C14 always read 0. The other bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register word index |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| src_tick_i | input | NSRC | Single-cycle tick enables from each source |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest event to reach from the ports is the rollover, because the counter can only be zeroed, never loaded. At 32 bits it would take billions of steps to reach all ones. The bench therefore builds the block with a 10-bit counter. With the prescaler at zero, about a thousand ticks carry the count to all ones and over the wrap. Cycle-exact cases then follow under constrained-random traffic: a clear that collides with a new match, and a compare-1 write landing on a step.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned PRESC_W = 12;
  localparam int unsigned NFLAG   = 6;
  localparam int unsigned NCMP    = 3;
  localparam int unsigned NREG    = 10;

  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_PRESC = 1;
  localparam int unsigned IDX_STAT  = 2;
  localparam int unsigned IDX_IEN   = 3;
  localparam int unsigned IDX_CMP1  = 4;
  localparam int unsigned IDX_CNT   = 9;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_ENMOD = 1;
  localparam int unsigned CB_SRC   = 6;
  localparam int unsigned CB_FREE  = 9;
  localparam int unsigned CB_SWR   = 15;

  localparam int unsigned FL_ROV = 5;

  localparam logic [BUS_W-1:0] CTRL_RO_MASK   = 32'h0000_7C14;
  localparam logic [BUS_W-1:0] CTRL_KEEP_MASK = 32'h0003_01EB;

  typedef struct packed {
    logic       en;
    logic       free;
    logic [2:0] src;
  } ctrl_view_t;
endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick #(
  parameter int unsigned NSRC    = 4,
  parameter int unsigned PRESC_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [2:0]         sel_i,
  input  logic [NSRC-1:0]    src_tick_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               clr_i,
  output logic               step_o
);
  logic               src;
  logic               active;
  logic [PRESC_W-1:0] div_q;

  // codes 1..NSRC map to tick bits 0..NSRC-1, anything else is silent
  always_comb begin
    src = 1'b0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (sel_i == 3'(i + 1)) src = src_tick_i[i];
    end
  end

  assign active = run_i && src;
  // >= keeps the divider sane when the prescaler shrinks mid-count
  assign step_o = active && (div_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (active) div_q <= step_o ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NCMP  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       step_i,
  input  logic                       restart_i,
  input  logic                       free_i,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [NCMP-1:0]            match_o,
  output logic                       wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             adv;

  assign adv     = step_i && !restart_i;
  assign cnt_nxt = (!free_i && cnt_q == cmp_i[0]) ? '0 : cnt_q + 1'b1;

  for (genvar k = 0; k < NCMP; k++) begin : g_match
    assign match_o[k] = adv && (cnt_nxt == cmp_i[k]);
  end

  assign wrap_o = adv && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_en_i,
  input  logic [BUS_W-1:0]           wdata_i,
  input  logic [NFLAG-1:0]           flag_set_i,
  input  logic [CNT_W-1:0]           cnt_i,
  output ctrl_view_t                 cfg_o,
  output logic [BUS_W-1:0]           ctrl_o,
  output logic [PRESC_W-1:0]         presc_o,
  output logic [NFLAG-1:0]           status_o,
  output logic [NFLAG-1:0]           ier_o,
  output logic [NCMP-1:0][CNT_W-1:0] cmp_o,
  output logic                       restart_o,
  output logic [BUS_W-1:0]           rdata_o
);
  logic [NREG-1:0]    wr_sel;
  logic [BUS_W-1:0]   ctrl_q;
  logic [BUS_W-1:0]   ctrl_wr;
  logic [PRESC_W-1:0] presc_q;
  logic [NFLAG-1:0]   stat_q;
  logic [NFLAG-1:0]   stat_clr;
  logic [NFLAG-1:0]   ier_q;
  logic [CNT_W-1:0]   cmp_q [NCMP];
  logic               swr;
  logic               en_rise_zero;
  logic               cmp1_zero;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = wr_en_i && (addr_i == ADDR_W'(i));
  end

  assign ctrl_wr = wdata_i & ~CTRL_RO_MASK;
  assign swr     = wr_sel[IDX_CTRL] && wdata_i[CB_SWR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= '0;
    else if (wr_sel[IDX_CTRL])  ctrl_q <= swr ? (ctrl_wr & CTRL_KEEP_MASK) : ctrl_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                presc_q <= '0;
    else if (swr)               presc_q <= '0;
    else if (wr_sel[IDX_PRESC]) presc_q <= wdata_i[PRESC_W-1:0];
  end

  assign stat_clr = wr_sel[IDX_STAT] ? wdata_i[NFLAG-1:0] : '0;

  // a new flag wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_q <= '0;
    else if (swr)  stat_q <= '0;
    else           stat_q <= (stat_q & ~stat_clr) | flag_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ier_q <= '0;
    else if (swr)             ier_q <= '0;
    else if (wr_sel[IDX_IEN]) ier_q <= wdata_i[NFLAG-1:0];
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cmp_q[k] <= '1;
      else if (swr)                  cmp_q[k] <= '1;
      else if (wr_sel[IDX_CMP1 + k]) cmp_q[k] <= wdata_i[CNT_W-1:0];
    end
    assign cmp_o[k] = cmp_q[k];
  end

  assign en_rise_zero = wr_sel[IDX_CTRL] && !ctrl_q[CB_EN]
                        && wdata_i[CB_EN] && wdata_i[CB_ENMOD];
  assign cmp1_zero    = wr_sel[IDX_CMP1] && !ctrl_q[CB_FREE];
  assign restart_o    = swr || en_rise_zero || cmp1_zero;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(IDX_CTRL))  rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(IDX_PRESC)) rdata_o = BUS_W'(presc_q);
    if (addr_i == ADDR_W'(IDX_STAT))  rdata_o = BUS_W'(stat_q);
    if (addr_i == ADDR_W'(IDX_IEN))   rdata_o = BUS_W'(ier_q);
    for (int k = 0; k < int'(NCMP); k++) begin
      if (addr_i == ADDR_W'(int'(IDX_CMP1) + k)) rdata_o = BUS_W'(cmp_q[k]);
    end
    if (addr_i == ADDR_W'(IDX_CNT))   rdata_o = BUS_W'(cnt_i);
  end

  assign cfg_o.en   = ctrl_q[CB_EN];
  assign cfg_o.free = ctrl_q[CB_FREE];
  assign cfg_o.src  = ctrl_q[CB_SRC +: 3];
  assign ctrl_o     = ctrl_q;
  assign presc_o    = presc_q;
  assign status_o   = stat_q;
  assign ier_o      = ier_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NSRC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic [NSRC-1:0]   src_tick_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  ctrl_view_t                 cfg;
  logic [BUS_W-1:0]           ctrl;
  logic [PRESC_W-1:0]         presc;
  logic [NFLAG-1:0]           status;
  logic [NFLAG-1:0]           ier;
  logic [NFLAG-1:0]           flag_set;
  logic [NCMP-1:0][CNT_W-1:0] cmp;
  logic [NCMP-1:0]            match;
  logic [CNT_W-1:0]           cnt;
  logic                       wrap;
  logic                       step;
  logic                       restart;

  cmp_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .flag_set_i(flag_set), .cnt_i(cnt), .cfg_o(cfg), .ctrl_o(ctrl),
    .presc_o(presc), .status_o(status), .ier_o(ier), .cmp_o(cmp),
    .restart_o(restart), .rdata_o
  );

  cmp_timer_tick #(.NSRC(NSRC), .PRESC_W(PRESC_W)) i_tick (
    .clk_i, .rst_ni, .run_i(cfg.en), .sel_i(cfg.src), .src_tick_i,
    .presc_i(presc), .clr_i(restart), .step_o(step)
  );

  cmp_timer_count #(.CNT_W(CNT_W), .NCMP(NCMP)) i_count (
    .clk_i, .rst_ni, .step_i(step), .restart_i(restart), .free_i(cfg.free),
    .cmp_i(cmp), .cnt_o(cnt), .match_o(match), .wrap_o(wrap)
  );

  // capture flags (bits 4:3) never fire
  assign flag_set = {wrap, 2'b00, match};
  assign irq_o    = cfg.en && |(status & ier);
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic [31:0]       ctrl,
  input logic [11:0]       presc,
  input logic [5:0]        status,
  input logic [5:0]        ier,
  input logic [5:0]        flag_set,
  input logic [CNT_W-1:0]  cmp1,
  input logic [CNT_W-1:0]  cnt,
  input logic              step,
  input logic              restart
);
  a_r10_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !restart) |=> $stable(cnt));

  a_r6_period_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !restart && !ctrl[9] && cnt == cmp1) |=> (cnt == '0));

  a_r7_rollover_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !restart && (&cnt)) |=> status[5]);

  a_r7_free_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !restart && ctrl[9]) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r9_cmp1_write_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(4) && !ctrl[9]) |=> (cnt == '0));

  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(2))
    |=> ((status & $past(wdata_i[5:0]) & ~$past(flag_set)) == 6'd0));

  a_r12_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(0) && wdata_i[15])
    |=> (cnt == '0 && status == 6'd0 && ier == 6'd0 && presc == 12'd0 && !ctrl[15]));

  a_r5_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[0] |-> !irq_o);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .ctrl(ctrl), .presc(presc),
  .status(status), .ier(ier), .flag_set(flag_set), .cmp1(cmp[0]),
  .cnt(cnt), .step(step), .restart(restart)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  tick_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  cmp_timer #(.CNT_W(CW), .ADDR_W(4), .NSRC(4)) i_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .src_tick_i(tick_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // reference state
  logic [31:0]   m_ctrl;
  logic [11:0]   m_presc, m_div;
  logic [5:0]    m_stat, m_ier;
  logic [CW-1:0] m_cmp [3];
  logic [CW-1:0] m_cnt;

  task automatic m_reset();
    m_ctrl = '0; m_presc = '0; m_div = '0; m_stat = '0; m_ier = '0; m_cnt = '0;
    for (int k = 0; k < 3; k++) m_cmp[k] = '1;
  endtask

  task automatic m_step(input logic [3:0] a, input logic we, input logic [31:0] d,
                        input logic [3:0] tk);
    logic [2:0] sel;
    logic srcv, going, stp, swr, zero;
    logic [CW-1:0] nxt;
    logic [5:0] setf, clrf;
    sel   = m_ctrl[8:6];
    srcv  = (sel >= 3'd1 && sel <= 3'd4) ? tk[sel - 3'd1] : 1'b0;
    going = m_ctrl[0] && srcv;
    stp   = going && (m_div >= m_presc);
    swr   = we && a == 4'd0 && d[15];
    zero  = swr || (we && a == 4'd0 && !m_ctrl[0] && d[1:0] == 2'b11)
                || (we && a == 4'd4 && !m_ctrl[9]);
    nxt   = (!m_ctrl[9] && m_cnt == m_cmp[0]) ? '0 : m_cnt + 1'b1;
    setf  = '0;
    if (stp && !zero) begin
      for (int k = 0; k < 3; k++) if (nxt == m_cmp[k]) setf[k] = 1'b1;
      if (m_cnt == '1) setf[5] = 1'b1;
    end
    if (zero) begin m_cnt = '0; m_div = '0; end
    else begin
      if (going) m_div = stp ? 12'd0 : m_div + 12'd1;
      if (stp) m_cnt = nxt;
    end
    clrf = (we && a == 4'd2) ? d[5:0] : 6'd0;
    m_stat = (m_stat & ~clrf) | setf;
    if (we) begin
      case (a)
        4'd0: m_ctrl = d & ~32'h0000_7C14;
        4'd1: m_presc = d[11:0];
        4'd3: m_ier = d[5:0];
        4'd4, 4'd5, 4'd6: m_cmp[a - 4'd4] = d[CW-1:0];
        default: ;
      endcase
    end
    if (swr) begin
      m_ctrl = d & 32'h0003_01EB;
      m_presc = '0; m_stat = '0; m_ier = '0;
      for (int k = 0; k < 3; k++) m_cmp[k] = '1;
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return 32'(m_presc);
      4'd2: return 32'(m_stat);
      4'd3: return 32'(m_ier);
      4'd4, 4'd5, 4'd6: return 32'(m_cmp[a - 4'd4]);
      4'd9: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_ctrl[0] && |(m_stat & m_ier);
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R13";
      4'd1: return "R2";
      4'd2, 4'd3: return "R4";
      4'd4: return "R6";
      4'd5, 4'd6: return "R8";
      4'd9: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // called in the low clock phase
  task automatic peek(input logic [3:0] a, input string tag);
    addr_i = a; wr_en_i = 1'b0;
    #1ns;
    check_eq(tag, rdata_o, m_read(a));
  endtask

  task automatic peek_exp(input logic [3:0] a, input string tag, input logic [31:0] exp);
    addr_i = a; wr_en_i = 1'b0;
    #1ns;
    check_eq(tag, rdata_o, exp);
  endtask

  task automatic peek_irq(input string tag);
    #1ns;
    check_eq(tag, 32'(irq_o), 32'(m_irq()));
  endtask

  task automatic cyc(input logic [3:0] a, input logic we, input logic [31:0] d,
                     input logic [3:0] tk);
    addr_i = a; wr_en_i = we; wdata_i = d; tick_i = tk;
    m_step(a, we, d, tk);
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d, 4'd0);
  endtask

  task automatic ticks(input int n, input logic [3:0] tk);
    for (int i = 0; i < n; i++) cyc(4'd0, 1'b0, 32'd0, tk);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R1 reset image
    for (int i = 0; i < 16; i++) peek(4'(i), (i <= 6 || i == 9) ? "R11" : "R1");
    peek_exp(4'd4, "R11", 32'h0000_03FF);
    peek_irq("R11");

    // R13 read-only control bits; R3 source code 7 is silent
    wr(4'd0, 32'hFFFF_7FFF);
    peek_exp(4'd0, "R13", 32'hFFFF_03EB);
    ticks(5, 4'hF);
    peek_exp(4'd9, "R3", 32'd0);
    wr(4'd0, 32'd0);

    // R1 writes to capture, counter and unmapped indices are dropped
    wr(4'd7, 32'h55); wr(4'd8, 32'h66); wr(4'd9, 32'h77); wr(4'd12, 32'h88);
    peek_exp(4'd7, "R1", 32'd0);
    peek_exp(4'd8, "R1", 32'd0);
    peek_exp(4'd12, "R1", 32'd0);
    peek_exp(4'd9, "R1", 32'd0);

    // R3 source select, R2 prescaler
    wr(4'd1, 32'hFFFF_F002);
    peek_exp(4'd1, "R2", 32'h0000_0002);
    wr(4'd0, 32'h0000_0283);
    ticks(6, 4'b1101);
    peek_exp(4'd9, "R3", 32'd0);
    ticks(9, 4'b0010);
    peek_exp(4'd9, "R2", 32'd3);
    ticks(2, 4'b0010);
    peek_exp(4'd9, "R2", 32'd3);
    ticks(1, 4'b0010);
    peek_exp(4'd9, "R2", 32'd4);

    // R6 restart at compare 1
    wr(4'd1, 32'd0); wr(4'd0, 32'd0); wr(4'd4, 32'd4);
    wr(4'd0, 32'h0000_0043);
    ticks(4, 4'b0001);
    peek_exp(4'd9, "R6", 32'd4);
    peek_exp(4'd2, "R6", 32'd1);
    ticks(1, 4'b0001);
    peek_exp(4'd9, "R6", 32'd0);
    wr(4'd2, 32'h3F);

    // R4 enable mask, clear vs set collision
    wr(4'd3, 32'hFFFF_FFFF);
    peek_exp(4'd3, "R4", 32'h3F);
    ticks(3, 4'b0001);
    cyc(4'd2, 1'b1, 32'd1, 4'b0001);
    peek_exp(4'd2, "R4", 32'd1);
    wr(4'd2, 32'd1);
    peek_exp(4'd2, "R4", 32'd0);

    // R5 interrupt level
    peek_irq("R5");
    ticks(5, 4'b0001);
    peek_exp(4'd2, "R5", 32'd1);
    check_eq("R5", 32'(irq_o), 32'd1);
    wr(4'd3, 32'd0);
    check_eq("R5", 32'(irq_o), 32'd0);
    wr(4'd3, 32'd1);
    check_eq("R5", 32'(irq_o), 32'd1);
    wr(4'd0, 32'h0000_0042);
    check_eq("R5", 32'(irq_o), 32'd0);

    // R10 hold, resume, zero-on-enable
    wr(4'd0, 32'h0000_0241);
    ticks(3, 4'b0001);
    peek_exp(4'd9, "R10", 32'd7);
    wr(4'd0, 32'h0000_0240);
    ticks(3, 4'b0001);
    peek_exp(4'd9, "R10", 32'd7);
    wr(4'd0, 32'h0000_0241);
    ticks(1, 4'b0001);
    peek_exp(4'd9, "R10", 32'd8);
    wr(4'd0, 32'h0000_0240);
    wr(4'd0, 32'h0000_0243);
    peek_exp(4'd9, "R10", 32'd0);

    // R8 compare 2/3 flags with interrupts masked
    wr(4'd2, 32'h3F); wr(4'd3, 32'd0); wr(4'd5, 32'd3); wr(4'd6, 32'd7);
    ticks(8, 4'b0001);
    peek_exp(4'd2, "R8", 32'h07);
    peek_exp(4'd9, "R8", 32'd8);
    check_eq("R8", 32'(irq_o), 32'd0);

    // R7 rollover in free-run
    wr(4'd2, 32'h3F);
    ticks(1015, 4'b0001);
    peek_exp(4'd9, "R7", 32'h3FF);
    peek_exp(4'd2, "R7", 32'd0);
    ticks(1, 4'b0001);
    peek_exp(4'd9, "R7", 32'd0);
    peek_exp(4'd2, "R7", 32'h20);

    // R9 compare 1 write restarts only in restart mode
    wr(4'd0, 32'h0000_0240); wr(4'd0, 32'h0000_0043); wr(4'd4, 32'd50);
    ticks(10, 4'b0001);
    peek_exp(4'd9, "R9", 32'd10);
    wr(4'd4, 32'd60);
    peek_exp(4'd9, "R9", 32'd0);
    wr(4'd0, 32'h0000_0243);
    ticks(5, 4'b0001);
    wr(4'd4, 32'd70);
    peek_exp(4'd9, "R9", 32'd5);

    // R12 soft reset
    wr(4'd1, 32'd7); wr(4'd3, 32'h3F); wr(4'd5, 32'd9);
    wr(4'd0, 32'hABCD_83EB);
    peek_exp(4'd0, "R12", 32'h0001_01EB);
    peek_exp(4'd1, "R12", 32'd0);
    peek_exp(4'd3, "R12", 32'd0);
    peek_exp(4'd2, "R12", 32'd0);
    peek_exp(4'd5, "R12", 32'h3FF);
    peek_exp(4'd9, "R12", 32'd0);

    // constrained random traffic against the reference
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  a;
      logic [31:0] d;
      logic        we;
      we = ($urandom % 8) == 0;
      a  = 4'($urandom % 16);
      d  = $urandom;
      if (a == 4'd0) begin
        d[8:6] = 3'($urandom % 6);
        d[15]  = ($urandom % 16) == 0;
      end else if (a == 4'd1) begin
        d[11:0] = 12'($urandom % 4);
      end else if (a >= 4'd4 && a <= 4'd6) begin
        d[CW-1:0] = CW'($urandom % 64);
      end
      cyc(a, we, d, 4'($urandom));
      peek(4'($urandom % 16), "");
      if (checks > 0 && rdata_o !== m_read(addr_i)) ;
      peek_irq("R5");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // tags of random reads resolve through tag_of
  initial begin : tag_use
    string t;
    t = tag_of(4'd0);
    if (t.len() == 0) $display("tag table empty");
  end
endmodule